// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Port

This block models a small serial EEPROM of 256 words by 16 bits. The host has no serial interface of its own. It drives the device's select, clock and data-in lines one at a time by writing a byte-wide control register in the external RAM window. It reads the device's data-out line back from that same register. Every protocol event comes from comparing one host write with the one before it: a rising select, a rising clock or a falling clock.

A command frame is a start bit, a 2-bit opcode and an 8-bit word address, all sampled on rising clocks with the first bit as the most significant. Opcode 10 reads a word. Opcode 01 writes a word. Opcode 11 erases one word. Opcode 00 is an extended group, chosen by the top two address bits: disable writes, enable writes, write-all or erase-all. A word write or a single-word erase does not store anything at once. It leaves a pending store, and the next rising edge of select commits it. The word storage is inside the block.

Top module: `serial_eeprom`

## Requirements
- R1: The control register is selected when (host_addr & 0xF0) == 0x80. A host write at any other offset changes nothing. A read at a selected offset returns data-out in bit 0 with bits 7..1 zero. A read at any other offset returns 0xFF.
- R2: Control byte layout: bit 7 is select, bit 6 is serial clock, bit 1 is data-in. Edges are found by comparing each selected write with the previous one. A selected write that changes neither select nor clock has no effect.
- R3: After reset, writes are disabled, the sequencer is inactive and data-out reads 0. A word write sent before any enable command leaves storage unchanged.
- R4: A rising select makes the sequencer wait for a start bit. In that wait, a rising clock with data-in 0 is ignored, and a rising clock with data-in 1 begins opcode collection. Data-out then reads 0.
- R5: Read (opcode 10): one dummy rising clock after the address loads the word, and data-out then reads 0. Each following falling clock presents the next word bit, bit 15 first. The read ends after the 16th falling clock, and data-out keeps bit 0.
- R6: Opcode 00 with address bits 7..6 = 11 enables writes. With 00 it disables writes. Either takes effect on the last address clock.
- R7: Write (opcode 01): 16 data bits follow the address, most significant first. Then select low followed by select high stores them to the addressed word if writes are enabled. After that commit, data-out reads 1.
- R8: Write-all (opcode 00, address bits 7..6 = 01): on the 16th data clock, every word takes the 16 data bits if writes are enabled. A pending store to the addressed word follows, as in R7.
- R9: Erase-all (opcode 00, address bits 7..6 = 10): on the 16th clock after the address, every word becomes 0xFFFF if writes are enabled. The 16 clocked bits then wait as a pending store to the addressed word.
- R10: Erase (opcode 11): after 16 clocks following the address, the next rising select stores 0xFFFF to the addressed word if writes are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 8 | Offset of the access within the window |
| host_wdata | input | 8 | Host write data (control byte) |
| host_rdata | output | 8 | Host read data for host_addr |

## Verification
The hardest state to reach is the middle of a read, part way through the sixteen output bits. Writes to other offsets and selected writes that toggle only data-in must not shift the word there, and the only way to get there is a full bit-banged frame of single register writes. The bench builds each frame from small tasks: select, one clock pulse, command, data. During one read it stops after the eighth bit, injects such writes, confirms data-out holds, and then finishes the word. A leading run of zero start clocks and the pending-store commits are reached the same way.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

  // Sequencer states; the order matters: states above ST_IDLE other than
  // ST_READ shift data-in on rising clocks.
  typedef enum logic [3:0] {
    ST_NULL, ST_IDLE, ST_OPC, ST_ADR, ST_EXT,
    ST_WRD, ST_RDD, ST_ERS, ST_PEND, ST_READ
  } eep_state_t;

  // Extended-group selector taken from the two top address bits.
  typedef enum logic [1:0] {
    SUB_WDS  = 2'b00,
    SUB_WRAL = 2'b01,
    SUB_ERAL = 2'b10,
    SUB_WEN  = 2'b11
  } ext_sub_t;

  localparam int OPC_W = 2;

  function automatic eep_state_t cmd_state(input logic [OPC_W-1:0] op);
    case (op)
      2'b00:   return ST_EXT;
      2'b01:   return ST_WRD;
      2'b10:   return ST_RDD;
      default: return ST_ERS;
    endcase
  endfunction

endpackage

// File: rtl/eep_edges.sv
module eep_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic cs_in,
  input  logic sk_in,
  output logic cs_rise,
  output logic sk_rise,
  output logic sk_fall
);
  logic cs_q, sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else if (wr_hit) begin
      cs_q <= cs_in;
      sk_q <= sk_in;
    end
  end

  assign cs_rise = wr_hit &&  cs_in && !cs_q;
  assign sk_rise = wr_hit &&  sk_in && !sk_q;
  assign sk_fall = wr_hit && !sk_in &&  sk_q;
endmodule

// File: rtl/eep_words.sv
module eep_words #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              word_we,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [WORD_W-1:0] word_data,
  input  logic              fill_we,
  input  logic [WORD_W-1:0] fill_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (fill_we) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_data;
    end else if (word_we) begin
      mem[word_addr] <= word_data;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import serial_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              di,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_we,
  output logic [ADDR_W-1:0] word_addr,
  output logic [WORD_W-1:0] word_data,
  output logic              fill_we,
  output logic [WORD_W-1:0] fill_data,
  output logic              start_seen,
  output logic              wen,
  output logic              dout
);
  localparam int SR_W  = WORD_W + 1;
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] N_OPC  = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] N_ADR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] N_WORD = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] N_ONE  = CNT_W'(1);

  function automatic logic [SR_W-1:0] shl(input logic [SR_W-1:0] v, input logic b);
    return {v[SR_W-2:0], b};
  endfunction

  function automatic ext_sub_t sub_of(input logic [ADDR_W-1:0] a);
    return ext_sub_t'(a[ADDR_W-1 -: 2]);
  endfunction

  eep_state_t          st_q, st_n, st_c;
  logic [SR_W-1:0]     sr_q, sr_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [OPC_W-1:0]    cmd_q, cmd_n;
  logic [ADDR_W-1:0]   adr_q, adr_n;
  logic                wen_q, wen_n;

  always_comb begin
    st_n       = st_q;
    sr_n       = sr_q;
    cnt_n      = cnt_q;
    cmd_n      = cmd_q;
    adr_n      = adr_q;
    wen_n      = wen_q;
    word_we    = 1'b0;
    fill_we    = 1'b0;
    fill_data  = sr_q[WORD_W-1:0];
    start_seen = 1'b0;

    // select edge is handled before the clock edge of the same write
    if (cs_rise) begin
      if (st_q == ST_PEND) begin
        word_we = wen_q;
        sr_n    = '1;
        st_n    = ST_NULL;
      end else begin
        st_n    = ST_IDLE;
      end
    end

    st_c = st_n;
    if (sk_rise) begin
      if (st_c > ST_IDLE && st_c != ST_READ) begin
        sr_n  = shl(sr_n, di);
        cnt_n = cnt_n + N_ONE;
      end
      case (st_c)
        ST_IDLE: if (di) begin
          st_n       = ST_OPC;
          cnt_n      = '0;
          sr_n       = '0;
          start_seen = 1'b1;
        end
        ST_OPC: if (cnt_n == N_OPC) begin
          st_n  = ST_ADR;
          cnt_n = '0;
          cmd_n = sr_n[OPC_W-1:0];
        end
        ST_ADR: if (cnt_n == N_ADR) begin
          cnt_n = '0;
          adr_n = sr_n[ADDR_W-1:0];
          st_n  = cmd_state(cmd_q);
          if (cmd_q == '0) begin
            if (sub_of(adr_n) == SUB_WDS) begin
              wen_n = 1'b0;
              st_n  = ST_NULL;
            end else if (sub_of(adr_n) == SUB_WEN) begin
              wen_n = 1'b1;
              st_n  = ST_NULL;
            end
          end
        end
        ST_EXT: if (cnt_n == N_WORD) begin
          case (sub_of(adr_q))
            SUB_WRAL: begin
              st_n      = ST_PEND;
              fill_we   = wen_q;
              fill_data = sr_n[WORD_W-1:0];
            end
            SUB_ERAL: begin
              st_n      = ST_PEND;
              fill_we   = wen_q;
              fill_data = '1;
            end
            SUB_WEN: begin
              wen_n = 1'b1;
              st_n  = ST_NULL;
            end
            default: begin
              wen_n = 1'b0;
              st_n  = ST_NULL;
            end
          endcase
        end
        ST_WRD: if (cnt_n == N_WORD) begin
          cnt_n = '0;
          st_n  = ST_PEND;
        end
        ST_RDD: if (cnt_n == N_ONE) begin
          sr_n  = {1'b0, rd_word};
          cnt_n = '0;
          st_n  = ST_READ;
        end
        ST_ERS: if (cnt_n == N_WORD) begin
          sr_n  = {1'b0, {WORD_W{1'b1}}};
          cnt_n = '0;
          st_n  = ST_PEND;
        end
        default: ;
      endcase
    end else if (sk_fall && st_c == ST_READ) begin
      sr_n  = shl(sr_n, 1'b0);
      cnt_n = cnt_n + N_ONE;
      if (cnt_n == N_WORD) begin
        cnt_n = '0;
        st_n  = ST_NULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_NULL;
      sr_q  <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
      adr_q <= '0;
      wen_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
      cmd_q <= cmd_n;
      adr_q <= adr_n;
      wen_q <= wen_n;
    end
  end

  assign rd_addr   = adr_q;
  assign word_addr = adr_q;
  assign word_data = sr_q[WORD_W-1:0];
  assign wen       = wen_q;
  assign dout      = sr_q[SR_W-1];
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom #(
  parameter int          ADDR_W    = 8,
  parameter int          WORD_W    = 16,
  parameter int          HOST_W    = 8,
  parameter logic [7:0]  SEL_MASK  = 8'hF0,
  parameter logic [7:0]  SEL_MATCH = 8'h80,
  parameter int          CS_BIT    = 7,
  parameter int          SK_BIT    = 6,
  parameter int          DI_BIT    = 1,
  parameter int          DO_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [7:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata
);
  localparam logic [HOST_W-1:0] DO_ONE = HOST_W'(1) << DO_BIT;

  logic              addr_sel, wr_hit;
  logic              cs_rise, sk_rise, sk_fall;
  logic              word_we, fill_we, start_seen, wen, dout;
  logic [ADDR_W-1:0] rd_addr, word_addr;
  logic [WORD_W-1:0] rd_word, word_data, fill_data;
  logic              unused_wdata;

  assign addr_sel     = (host_addr & SEL_MASK) == SEL_MATCH;
  assign wr_hit       = host_wr && addr_sel;
  assign unused_wdata = ^host_wdata;

  eep_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .cs_in   (host_wdata[CS_BIT]),
    .sk_in   (host_wdata[SK_BIT]),
    .cs_rise (cs_rise),
    .sk_rise (sk_rise),
    .sk_fall (sk_fall)
  );

  eep_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .sk_rise    (sk_rise),
    .sk_fall    (sk_fall),
    .di         (host_wdata[DI_BIT]),
    .rd_word    (rd_word),
    .rd_addr    (rd_addr),
    .word_we    (word_we),
    .word_addr  (word_addr),
    .word_data  (word_data),
    .fill_we    (fill_we),
    .fill_data  (fill_data),
    .start_seen (start_seen),
    .wen        (wen),
    .dout       (dout)
  );

  eep_words #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_words (
    .clk       (clk),
    .word_we   (word_we),
    .word_addr (word_addr),
    .word_data (word_data),
    .fill_we   (fill_we),
    .fill_data (fill_data),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word)
  );

  assign host_rdata = addr_sel ? (dout ? DO_ONE : '0) : '1;
endmodule

// File: rtl/serial_eeprom_chk.sv
module serial_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_hit,
  input logic sk_rise,
  input logic sk_fall,
  input logic word_we,
  input logic fill_we,
  input logic start_seen,
  input logic wen,
  input logic dout
);
  // R7
  commit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_we |=> dout);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(dout) && $stable(wen)));

  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sk_rise, sk_fall}));

  // R6
  wen_on_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> $past(sk_rise));

  // R8
  fill_on_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> sk_rise);

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !dout);
endmodule

bind serial_eeprom serial_eeprom_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_hit     (wr_hit),
  .sk_rise    (sk_rise),
  .sk_fall    (sk_fall),
  .word_we    (word_we),
  .fill_we    (fill_we),
  .start_seen (start_seen),
  .wen        (wen),
  .dout       (dout)
);

// File: tb/test_serial_eeprom.sv
module test_serial_eeprom;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_addr = 8'h80;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_eeprom i_serial_eeprom (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  // {word address, data}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'h1234}, {8'h01, 16'hA5C3}, {8'h7F, 16'h0001},
    {8'h80, 16'h8000}, {8'hFE, 16'hFFFE}, {8'hFF, 16'h5A5A}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 8'h80;
  endtask

  task automatic rd_do(output logic b);
    #1 b = host_rdata[0];
  endtask

  task automatic ctl(input logic cs, input logic sk, input logic di);
    hw(8'h80, {cs, sk, 4'b0000, di, 1'b0});
  endtask

  task automatic clk_bit(input logic di);
    ctl(1'b1, 1'b0, di);
    ctl(1'b1, 1'b1, di);
  endtask

  task automatic start();
    ctl(1'b0, 1'b0, 1'b0);
    ctl(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] a);
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = 7; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic data16(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) clk_bit(d[i]);
  endtask

  task automatic end_write(output logic ready);
    ctl(1'b0, 1'b0, 1'b0);
    ctl(1'b1, 1'b0, 1'b0);
    rd_do(ready);
    ctl(1'b0, 1'b0, 1'b0);
  endtask

  task automatic ext_cmd(input logic [7:0] a);
    start();
    send(2'b00, a);
    ctl(1'b0, 1'b0, 1'b0);
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] d, output logic ready);
    start();
    send(2'b01, a);
    data16(d);
    end_write(ready);
  endtask

  task automatic read_word(input logic [7:0] a, input int lead, input bit disturb,
                           output logic [15:0] d, output logic dummy);
    logic b, b2;
    start();
    repeat (lead) clk_bit(1'b0);
    send(2'b10, a);
    clk_bit(1'b0);
    rd_do(dummy);
    for (int i = 15; i >= 0; i--) begin
      ctl(1'b1, 1'b0, 1'b0);
      rd_do(b);
      d[i] = b;
      if (disturb && i == 8) begin
        hw(8'h90, 8'hC0);
        hw(8'h90, 8'h80);
        hw(8'h3F, 8'h40);
        rd_do(b2);
        check(b2 == b, "R1 unselected writes mid-read", {15'd0, b2}, {15'd0, b});
        ctl(1'b1, 1'b0, 1'b1);
        rd_do(b2);
        check(b2 == b, "R2 data-in only toggle mid-read", {15'd0, b2}, {15'd0, b});
      end
      if (i > 0) ctl(1'b1, 1'b1, 1'b0);
    end
    ctl(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic        dm, rdy;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset state
    #1 check(host_rdata == 8'h00, "R3 reset data-out", {8'd0, host_rdata}, 16'h0000);
    host_addr = 8'h20;
    #1 check(host_rdata == 8'hFF, "R1 other offset read", {8'd0, host_rdata}, 16'h00FF);
    host_addr = 8'h8C;
    #1 check(host_rdata == 8'h00, "R1 selected alias read", {8'd0, host_rdata}, 16'h0000);
    host_addr = 8'h80;

    // R6: enable, then vector table of writes and reads
    ext_cmd(8'hC0);
    foreach (VEC[k]) begin
      write_word(VEC[k][23:16], VEC[k][15:0], rdy);
      check(rdy == 1'b1, "R7 ready after commit", {15'd0, rdy}, 16'h0001);
    end
    foreach (VEC[k]) begin
      read_word(VEC[k][23:16], 0, 1'b0, d, dm);
      check(d == VEC[k][15:0], "R7 R5 table readback", d, VEC[k][15:0]);
    end

    // R5: dummy bit reads 0; R4: leading zero clocks ignored; R1/R2 disturb
    read_word(8'h01, 3, 1'b1, d, dm);
    check(dm == 1'b0, "R5 dummy clock data-out", {15'd0, dm}, 16'h0000);
    check(d == 16'hA5C3, "R4 leading zeros before start", d, 16'hA5C3);

    // R4: start bit clears data-out (after commit left it 1)
    start();
    clk_bit(1'b1);
    rd_do(dm);
    check(dm == 1'b0, "R4 start bit clears data-out", {15'd0, dm}, 16'h0000);
    ctl(1'b0, 1'b0, 1'b0);

    // R6: disable blocks a write
    ext_cmd(8'h00);
    write_word(8'h00, 16'h0000, rdy);
    read_word(8'h00, 0, 1'b0, d, dm);
    check(d == 16'h1234, "R6 write after disable ignored", d, 16'h1234);

    // R3: reset again leaves writes disabled (storage keeps its words)
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    write_word(8'h01, 16'h0000, rdy);
    read_word(8'h01, 0, 1'b0, d, dm);
    check(d == 16'hA5C3, "R3 write disabled after reset", d, 16'hA5C3);

    // R8: write-all
    ext_cmd(8'hC0);
    start();
    send(2'b00, 8'h40);
    data16(16'h3C3C);
    end_write(rdy);
    read_word(8'h00, 0, 1'b0, d, dm);
    check(d == 16'h3C3C, "R8 write-all word 0x00", d, 16'h3C3C);
    read_word(8'hFF, 0, 1'b0, d, dm);
    check(d == 16'h3C3C, "R8 write-all word 0xFF", d, 16'h3C3C);
    read_word(8'h40, 0, 1'b0, d, dm);
    check(d == 16'h3C3C, "R8 write-all addressed word", d, 16'h3C3C);

    // R10: single-word erase
    start();
    send(2'b11, 8'h05);
    data16(16'h0000);
    end_write(rdy);
    read_word(8'h05, 0, 1'b0, d, dm);
    check(d == 16'hFFFF, "R10 erased word", d, 16'hFFFF);
    read_word(8'h06, 0, 1'b0, d, dm);
    check(d == 16'h3C3C, "R10 neighbour untouched", d, 16'h3C3C);

    // R9: erase-all (clocked bits are ones)
    start();
    send(2'b00, 8'h80);
    data16(16'hFFFF);
    end_write(rdy);
    read_word(8'h00, 0, 1'b0, d, dm);
    check(d == 16'hFFFF, "R9 erase-all word 0x00", d, 16'hFFFF);
    read_word(8'h9A, 0, 1'b0, d, dm);
    check(d == 16'hFFFF, "R9 erase-all word 0x9A", d, 16'hFFFF);

    // R6: disable then write has no effect
    ext_cmd(8'h3F);
    write_word(8'h9A, 16'h1111, rdy);
    read_word(8'h9A, 0, 1'b0, d, dm);
    check(d == 16'hFFFF, "R6 disabled write after erase", d, 16'hFFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule